// File: doc/BRIEF.md
# Transceiver Interrupt Vector Controller

This block turns the status of a serial transceiver into three prioritised interrupt requests and a 16-bit vector for the CPU. The three requests are receiver, transmitter and line turn-around, in that order of priority. The receiver request can come from one of several status sources, chosen by a 2-bit select. Each latched request is cleared by the register access that matches the event that set it. There is no generic acknowledge.

Status inputs are sampled every clock. A request is latched on the rising edge of its source, so a level that stays high does not re-arm the request after it has been cleared. A transceiver reset input forces the transmitter request pending and clears all the others. The vector output always shows the highest-priority pending request. A global enable gates only the request line.

Top module: `xcvr_irq_vector`

## Requirements
- R1: The receiver request has priority over the transmitter request, and the transmitter request has priority over the turn-around request. `irq_vec[5:0]` shows the address of the highest pending request: 6'b000100 for the receiver, 6'b001000 for the transmitter, 6'b001100 for turn-around.
- R2: `irq_vec[15:8]` equals `vec_base` and `irq_vec[7:6]` is 2'b00. When nothing is pending, `irq_vec[5:0]` is 6'b000000.
- R3: `irq_req` is high exactly when `gie` is high and at least one request is pending. `irq_vec` does not depend on `gie`.
- R4: With `rx_sel`=2'b00, a rising `st_fifo_full` sets the receiver request, and a data-register read (`acc_rtr_rd`) clears it. A rising `st_rx_err` also sets the receiver request. That error request is cleared only by an error-register read (`acc_ecr_rd`), not by a data-register read.
- R5: With `rx_sel`=2'b01, a rising `st_data_avail` sets the receiver request and `acc_rtr_rd` clears it. In this mode `st_fifo_full` has no effect.
- R6: With `rx_sel`=2'b10, no status input sets the receiver request.
- R7: With `rx_sel`=2'b11, a rising `st_rx_active` sets the receiver request. Either `acc_rtr_rd` or `acc_ecr_rd` clears it.
- R8: A rising `st_tx_empty` sets the transmitter request, and a data-register write (`acc_rtr_wr`) clears it.
- R9: A cycle with `xcvr_rst` high leaves the transmitter request pending and clears the receiver and turn-around requests. It takes precedence over any status edge in the same cycle.
- R10: A rising `st_end_seq` sets the turn-around request. Either `acc_rtr_wr` or `acc_lta_clr_wr` clears it.
- R11: While `addr_filt_en` is high, a rising `st_end_seq` sets the turn-around request only if `addr_match` is high in the same cycle.
- R12: A status edge in the same cycle as the access that clears its request leaves the request pending.
- R13: A status input held high after its request has been cleared does not set the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xcvr_rst | input | 1 | Transceiver reset strobe |
| gie | input | 1 | Global interrupt enable |
| rx_sel | input | 2 | Receiver interrupt source select |
| vec_base | input | 8 | Vector base, upper byte of the vector |
| st_fifo_full | input | 1 | Receive FIFO full |
| st_data_avail | input | 1 | Receive data available |
| st_rx_err | input | 1 | Receive error detected |
| st_rx_active | input | 1 | Valid start sequence seen |
| st_tx_empty | input | 1 | Transmit FIFO empty |
| st_end_seq | input | 1 | Valid end sequence seen |
| addr_filt_en | input | 1 | Address-filtered mode active |
| addr_match | input | 1 | Current message had an address match |
| acc_rtr_rd | input | 1 | Data register read strobe |
| acc_rtr_wr | input | 1 | Data register write strobe |
| acc_ecr_rd | input | 1 | Error register read strobe |
| acc_lta_clr_wr | input | 1 | Write of one to the turn-around clear bit |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector of the highest pending request |
| rx_pend | output | 1 | Receiver request pending |
| tx_pend | output | 1 | Transmitter request pending |
| lta_pend | output | 1 | Turn-around request pending |

## Verification
The hardest case to reach is the receiver request while it is held by an error and by a data event at once, because each half clears only through its own register access. The stimulus raises both sources, does a data-register read and checks that the request stays pending, then does an error-register read and checks that it drops. Same-cycle collisions are produced by driving a status edge and its clearing strobe between the same pair of clock edges. Priority is checked by stacking all three requests and removing them one at a time.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int unsigned ADDR_W = 6;
   localparam int unsigned GAP_W  = 2;
   localparam int unsigned NSRC   = 5;

   localparam int unsigned SRC_RXDATA = 0;
   localparam int unsigned SRC_RXERR  = 1;
   localparam int unsigned SRC_RXACT  = 2;
   localparam int unsigned SRC_TX     = 3;
   localparam int unsigned SRC_LTA    = 4;

   localparam logic [ADDR_W-1:0] ADDR_RX  = 6'b000100;
   localparam logic [ADDR_W-1:0] ADDR_TX  = 6'b001000;
   localparam logic [ADDR_W-1:0] ADDR_LTA = 6'b001100;

   typedef enum logic [1:0] {
      RXSEL_FULL_ERR = 2'b00,
      RXSEL_DAV_ERR  = 2'b01,
      RXSEL_NONE     = 2'b10,
      RXSEL_ACTIVE   = 2'b11
   } rx_sel_e;
endpackage

// File: rtl/xirq_rx_route.sv
module xirq_rx_route
   import xirq_pkg::*;
(
   input  logic [1:0] rx_sel,
   input  logic       st_fifo_full,
   input  logic       st_data_avail,
   input  logic       st_rx_err,
   input  logic       st_rx_active,
   input  logic       acc_rtr_rd,
   input  logic       acc_ecr_rd,
   output logic [2:0] rx_src,
   output logic [2:0] rx_clr
);
   rx_sel_e sel;
   assign sel = rx_sel_e'(rx_sel);

   always_comb begin
      rx_src = '0;
      unique case (sel)
         RXSEL_FULL_ERR: begin
            rx_src[SRC_RXDATA] = st_fifo_full;
            rx_src[SRC_RXERR]  = st_rx_err;
         end
         RXSEL_DAV_ERR: begin
            rx_src[SRC_RXDATA] = st_data_avail;
            rx_src[SRC_RXERR]  = st_rx_err;
         end
         RXSEL_ACTIVE: rx_src[SRC_RXACT] = st_rx_active;
         default: rx_src = '0;
      endcase
   end

   always_comb begin
      rx_clr[SRC_RXDATA] = acc_rtr_rd;
      rx_clr[SRC_RXERR]  = acc_ecr_rd;
      rx_clr[SRC_RXACT]  = acc_rtr_rd | acc_ecr_rd;
   end
endmodule

// File: rtl/xirq_flag_bank.sv
module xirq_flag_bank #(
   parameter int unsigned N          = 5,
   parameter bit          EDGE_SENSE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   input  logic [N-1:0] arm,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] fset,
   input  logic [N-1:0] fclr,
   output logic [N-1:0] pend
);
   logic [N-1:0] ev;

   for (genvar i = 0; i < N; i++) begin : g_flag
      if (EDGE_SENSE) begin : g_edge
         logic prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= src[i];
         end
         assign ev[i] = src[i] & ~prev & arm[i];
      end else begin : g_level
         assign ev[i] = src[i] & arm[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend[i] <= 1'b0;
         else if (fclr[i])  pend[i] <= 1'b0;
         else if (fset[i])  pend[i] <= 1'b1;
         else if (ev[i])    pend[i] <= 1'b1;
         else if (clr[i])   pend[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/xirq_vec_sel.sv
module xirq_vec_sel
   import xirq_pkg::*;
#(
   parameter int unsigned BASE_W = 8,
   localparam int unsigned VEC_W = BASE_W + GAP_W + ADDR_W
) (
   input  logic [BASE_W-1:0] vec_base,
   input  logic              rx_any,
   input  logic              tx_any,
   input  logic              lta_any,
   output logic [VEC_W-1:0]  vec,
   output logic              any
);
   logic [ADDR_W-1:0] addr;

   always_comb begin
      if (rx_any)       addr = ADDR_RX;
      else if (tx_any)  addr = ADDR_TX;
      else if (lta_any) addr = ADDR_LTA;
      else              addr = '0;
   end

   assign any = rx_any | tx_any | lta_any;
   assign vec = {vec_base, {GAP_W{1'b0}}, addr};
endmodule

// File: rtl/xcvr_irq_vector.sv
module xcvr_irq_vector
   import xirq_pkg::*;
#(
   parameter int unsigned BASE_W     = 8,
   parameter bit          EDGE_SENSE = 1'b1,
   localparam int unsigned VEC_W     = BASE_W + GAP_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xcvr_rst,
   input  logic              gie,
   input  logic [1:0]        rx_sel,
   input  logic [BASE_W-1:0] vec_base,
   input  logic              st_fifo_full,
   input  logic              st_data_avail,
   input  logic              st_rx_err,
   input  logic              st_rx_active,
   input  logic              st_tx_empty,
   input  logic              st_end_seq,
   input  logic              addr_filt_en,
   input  logic              addr_match,
   input  logic              acc_rtr_rd,
   input  logic              acc_rtr_wr,
   input  logic              acc_ecr_rd,
   input  logic              acc_lta_clr_wr,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   output logic              rx_pend,
   output logic              tx_pend,
   output logic              lta_pend
);
   if (BASE_W < 1 || BASE_W > 16) begin : g_bad_base
      $error("xcvr_irq_vector: BASE_W out of range");
   end
   if (NSRC != 5) begin : g_bad_nsrc
      $error("xcvr_irq_vector: source count mismatch");
   end

   logic [2:0]      rx_src, rx_clr;
   logic [NSRC-1:0] src, arm, clr, fset, fclr, pend;
   logic            lta_arm, any;

   xirq_rx_route u_route (
      .rx_sel        (rx_sel),
      .st_fifo_full  (st_fifo_full),
      .st_data_avail (st_data_avail),
      .st_rx_err     (st_rx_err),
      .st_rx_active  (st_rx_active),
      .acc_rtr_rd    (acc_rtr_rd),
      .acc_ecr_rd    (acc_ecr_rd),
      .rx_src        (rx_src),
      .rx_clr        (rx_clr)
   );

   assign lta_arm = ~addr_filt_en | addr_match;

   always_comb begin
      src  = '0;
      arm  = '1;
      clr  = '0;
      fset = '0;
      fclr = '0;
      src[SRC_RXACT:SRC_RXDATA]  = rx_src;
      clr[SRC_RXACT:SRC_RXDATA]  = rx_clr;
      fclr[SRC_RXACT:SRC_RXDATA] = {3{xcvr_rst}};
      src[SRC_TX]   = st_tx_empty;
      clr[SRC_TX]   = acc_rtr_wr;
      fset[SRC_TX]  = xcvr_rst;
      src[SRC_LTA]  = st_end_seq;
      arm[SRC_LTA]  = lta_arm;
      clr[SRC_LTA]  = acc_rtr_wr | acc_lta_clr_wr;
      fclr[SRC_LTA] = xcvr_rst;
   end

   xirq_flag_bank #(.N(NSRC), .EDGE_SENSE(EDGE_SENSE)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .src  (src),
      .arm  (arm),
      .clr  (clr),
      .fset (fset),
      .fclr (fclr),
      .pend (pend)
   );

   assign rx_pend  = |pend[SRC_RXACT:SRC_RXDATA];
   assign tx_pend  = pend[SRC_TX];
   assign lta_pend = pend[SRC_LTA];

   xirq_vec_sel #(.BASE_W(BASE_W)) u_vec (
      .vec_base(vec_base),
      .rx_any  (rx_pend),
      .tx_any  (tx_pend),
      .lta_any (lta_pend),
      .vec     (irq_vec),
      .any     (any)
   );

   assign irq_req = gie & any;
endmodule

// File: rtl/xirq_checker.sv
module xirq_checker #(
   parameter int unsigned VEC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xcvr_rst,
   input logic             gie,
   input logic [1:0]       rx_sel,
   input logic             st_end_seq,
   input logic             acc_lta_clr_wr,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic             rx_pend,
   input logic             tx_pend,
   input logic             lta_pend
);
   assert_rx_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pend |-> irq_vec[5:0] == 6'b000100);

   assert_tx_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pend && !rx_pend) |-> irq_vec[5:0] == 6'b001000);

   assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vec[7:6] == 2'b00);

   assert_req_needs_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (rx_pend || tx_pend || lta_pend));

   assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_sel == 2'b10 && !rx_pend && !xcvr_rst) |=> !rx_pend);

   assert_xrst_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xcvr_rst |=> (tx_pend && !rx_pend && !lta_pend));

   assert_lta_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_lta_clr_wr && !st_end_seq) |=> !lta_pend);
endmodule

bind xcvr_irq_vector xirq_checker #(.VEC_W(VEC_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .xcvr_rst      (xcvr_rst),
   .gie           (gie),
   .rx_sel        (rx_sel),
   .st_end_seq    (st_end_seq),
   .acc_lta_clr_wr(acc_lta_clr_wr),
   .irq_req       (irq_req),
   .irq_vec       (irq_vec),
   .rx_pend       (rx_pend),
   .tx_pend       (tx_pend),
   .lta_pend      (lta_pend)
);

// File: tb/xcvr_irq_vector_test.sv
`timescale 1ns/1ps
module xcvr_irq_vector_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xcvr_rst = 1'b0, gie = 1'b1;
   logic [1:0]  rx_sel = 2'b00;
   logic [7:0]  vec_base = 8'hA5;
   logic        st_fifo_full = 0, st_data_avail = 0, st_rx_err = 0, st_rx_active = 0;
   logic        st_tx_empty = 0, st_end_seq = 0, addr_filt_en = 0, addr_match = 0;
   logic        acc_rtr_rd = 0, acc_rtr_wr = 0, acc_ecr_rd = 0, acc_lta_clr_wr = 0;
   logic        irq_req, rx_pend, tx_pend, lta_pend;
   logic [15:0] irq_vec;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   xcvr_irq_vector uut (
      .clk(clk), .rst_n(rst_n), .xcvr_rst(xcvr_rst), .gie(gie), .rx_sel(rx_sel),
      .vec_base(vec_base), .st_fifo_full(st_fifo_full), .st_data_avail(st_data_avail),
      .st_rx_err(st_rx_err), .st_rx_active(st_rx_active), .st_tx_empty(st_tx_empty),
      .st_end_seq(st_end_seq), .addr_filt_en(addr_filt_en), .addr_match(addr_match),
      .acc_rtr_rd(acc_rtr_rd), .acc_rtr_wr(acc_rtr_wr), .acc_ecr_rd(acc_ecr_rd),
      .acc_lta_clr_wr(acc_lta_clr_wr), .irq_req(irq_req), .irq_vec(irq_vec),
      .rx_pend(rx_pend), .tx_pend(tx_pend), .lta_pend(lta_pend)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int pend3();
      return {29'd0, rx_pend, tx_pend, lta_pend};
   endfunction

   task automatic idle_all();
      {st_fifo_full, st_data_avail, st_rx_err, st_rx_active, st_tx_empty, st_end_seq} = '0;
      {acc_rtr_rd, acc_rtr_wr, acc_ecr_rd, acc_lta_clr_wr, xcvr_rst} = '0;
      tick();
   endtask

   task automatic t_reset();
      chk("R2 reset vector", irq_vec, 16'hA500);
      chk("R3 reset req", irq_req, 0);
      chk("R2 reset pend", pend3(), 0);
   endtask

   task automatic t_sel00();
      rx_sel = 2'b00;
      st_fifo_full = 1; tick(); st_fifo_full = 0;
      chk("R4 full sets", rx_pend, 1);
      chk("R1 rx vector", irq_vec, 16'hA504);
      chk("R3 req with gie", irq_req, 1);
      acc_ecr_rd = 1; tick(); acc_ecr_rd = 0;
      chk("R4 ecr read keeps full", rx_pend, 1);
      acc_rtr_rd = 1; tick(); acc_rtr_rd = 0;
      chk("R4 rtr read clears full", rx_pend, 0);
      st_rx_err = 1; tick(); st_rx_err = 0;
      chk("R4 err sets", rx_pend, 1);
      acc_rtr_rd = 1; tick(); acc_rtr_rd = 0;
      chk("R4 rtr read keeps err", rx_pend, 1);
      acc_ecr_rd = 1; tick(); acc_ecr_rd = 0;
      chk("R4 ecr read clears err", rx_pend, 0);
      st_fifo_full = 1; st_rx_err = 1; tick(); st_fifo_full = 0; st_rx_err = 0;
      acc_rtr_rd = 1; tick(); acc_rtr_rd = 0;
      chk("R4 both: rtr leaves err", rx_pend, 1);
      acc_ecr_rd = 1; tick(); acc_ecr_rd = 0;
      chk("R4 both: ecr clears rest", rx_pend, 0);
   endtask

   task automatic t_sel01();
      rx_sel = 2'b01; tick();
      st_fifo_full = 1; tick(); st_fifo_full = 0;
      chk("R5 full ignored", rx_pend, 0);
      st_data_avail = 1; tick(); st_data_avail = 0;
      chk("R5 dav sets", rx_pend, 1);
      acc_rtr_rd = 1; tick(); acc_rtr_rd = 0;
      chk("R5 rtr read clears", rx_pend, 0);
   endtask

   task automatic t_sel10();
      rx_sel = 2'b10; tick();
      st_fifo_full = 1; st_data_avail = 1; st_rx_err = 1; st_rx_active = 1; tick();
      idle_all();
      chk("R6 reserved no rx", rx_pend, 0);
      chk("R6 reserved vector", irq_vec, 16'hA500);
   endtask

   task automatic t_sel11();
      rx_sel = 2'b11; tick();
      st_rx_active = 1; tick(); st_rx_active = 0;
      chk("R7 active sets", rx_pend, 1);
      acc_ecr_rd = 1; tick(); acc_ecr_rd = 0;
      chk("R7 ecr clears", rx_pend, 0);
      st_rx_active = 1; tick(); st_rx_active = 0;
      chk("R7 active sets again", rx_pend, 1);
      acc_rtr_rd = 1; tick(); acc_rtr_rd = 0;
      chk("R7 rtr clears", rx_pend, 0);
   endtask

   task automatic t_tx();
      st_tx_empty = 1; tick();
      chk("R8 empty sets", tx_pend, 1);
      chk("R1 tx vector", irq_vec, 16'hA508);
      acc_rtr_wr = 1; tick(); acc_rtr_wr = 0;
      chk("R8 write clears", tx_pend, 0);
      tick(); tick();
      chk("R13 held empty no reset", tx_pend, 0);
      st_tx_empty = 0; tick();
   endtask

   task automatic t_lta();
      addr_filt_en = 0;
      st_end_seq = 1; tick(); st_end_seq = 0;
      chk("R10 end seq sets", lta_pend, 1);
      chk("R1 lta vector", irq_vec, 16'hA50C);
      acc_lta_clr_wr = 1; tick(); acc_lta_clr_wr = 0;
      chk("R10 clear bit clears", lta_pend, 0);
      st_end_seq = 1; tick(); st_end_seq = 0;
      acc_rtr_wr = 1; tick(); acc_rtr_wr = 0;
      chk("R10 data write clears", lta_pend, 0);
   endtask

   task automatic t_filter();
      addr_filt_en = 1; addr_match = 0;
      st_end_seq = 1; tick(); st_end_seq = 0; tick();
      chk("R11 no match ignored", lta_pend, 0);
      addr_match = 1;
      st_end_seq = 1; tick(); st_end_seq = 0;
      chk("R11 match sets", lta_pend, 1);
      acc_lta_clr_wr = 1; tick(); acc_lta_clr_wr = 0;
      addr_filt_en = 0; addr_match = 0;
   endtask

   task automatic t_prio();
      rx_sel = 2'b11; tick();
      st_rx_active = 1; st_tx_empty = 1; st_end_seq = 1; tick();
      st_rx_active = 0; st_end_seq = 0;
      chk("R1 all pending", pend3(), 7);
      chk("R1 rx wins", irq_vec, 16'hA504);
      gie = 0; #1;
      chk("R3 gie off req", irq_req, 0);
      chk("R3 gie off vector", irq_vec, 16'hA504);
      gie = 1;
      acc_rtr_rd = 1; tick(); acc_rtr_rd = 0;
      chk("R1 tx over lta", irq_vec, 16'hA508);
      acc_rtr_wr = 1; tick(); acc_rtr_wr = 0;
      chk("R2 none pending", irq_vec, 16'hA500);
      chk("R3 none req", irq_req, 0);
      st_tx_empty = 0; tick();
   endtask

   task automatic t_same_cycle();
      st_tx_empty = 1; acc_rtr_wr = 1; tick(); acc_rtr_wr = 0;
      chk("R12 tx edge beats write", tx_pend, 1);
      acc_rtr_wr = 1; tick(); acc_rtr_wr = 0; st_tx_empty = 0; tick();
      st_end_seq = 1; acc_lta_clr_wr = 1; tick(); st_end_seq = 0; acc_lta_clr_wr = 0;
      chk("R12 lta edge beats clear", lta_pend, 1);
      acc_lta_clr_wr = 1; tick(); acc_lta_clr_wr = 0;
      rx_sel = 2'b01; tick();
      st_data_avail = 1; acc_rtr_rd = 1; tick(); st_data_avail = 0; acc_rtr_rd = 0;
      chk("R12 dav edge beats read", rx_pend, 1);
      acc_rtr_rd = 1; tick(); acc_rtr_rd = 0;
   endtask

   task automatic t_xrst();
      rx_sel = 2'b11; tick();
      st_rx_active = 1; st_end_seq = 1; tick(); st_rx_active = 0; st_end_seq = 0;
      chk("R9 pre state", pend3(), 5);
      xcvr_rst = 1; tick(); xcvr_rst = 0;
      chk("R9 reset state", pend3(), 2);
      chk("R9 reset vector", irq_vec, 16'hA508);
      xcvr_rst = 1; st_end_seq = 1; st_rx_active = 1; tick();
      xcvr_rst = 0; st_end_seq = 0; st_rx_active = 0;
      chk("R9 reset beats edges", pend3(), 2);
      acc_rtr_wr = 1; tick(); acc_rtr_wr = 0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_sel00();
      t_sel01();
      t_sel10();
      t_sel11();
      t_tx();
      t_lta();
      t_filter();
      t_prio();
      t_same_cycle();
      t_xrst();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule